// File: doc/BRIEF.md
# Clocked Programmable Tap Delay Line

The block delays a one-bit signal by a whole number of clock cycles picked from 128 settings. A seven-bit unsigned select input chooses the setting. The delay is a fixed base latency plus the select value times a per-step increment. Both the base and the step are parameters counted in clock cycles. The delayed signal leaves on a true output and on a complementary output. An active-low enable can clamp both outputs to fixed opposite levels.

The select is not captured. The tap is chosen from the live select value on every cycle, so the select must stay steady while data is moving through the line. Because the line stores history, some events can put stale data at the tap: raising the select, or disabling while the line is busy. A settling flag marks the cycles in which such stale data may show up.

The flag is driven by a small state machine with three states:
- `ST_IDLE`: the flag is low.
- `ST_ADDR_SETTLE`: a select increase is settling. It is entered from any state except a disable window, on a select increase. In this state another increase reloads the window. When the countdown reaches its end, the machine goes back to `ST_IDLE`.
- `ST_DIS_SETTLE`: a disable is clearing. It is entered from any state on a disable while the line or the input holds a one, provided the current requirement is non-zero. It goes back to `ST_IDLE` once the clearing condition has held long enough.

Top module: `tapdelay_prog`

## Requirements
- R1: With select value `a` (7-bit unsigned binary, 0 to 127) held steady, a value sampled on `din_i` at clock edge k appears on `q_o` in the cycle after edge k + BASE_CYC + a*STEP_CYC − 1. The delay therefore rises strictly with `a`.
- R2: The select is used live. In the cycle after a select change, `q_o` already shows the input sample that lies the new delay back.
- R3: `qn_o` is always the logical inverse of `q_o`.
- R4: While `oe_n_i` is 1, `q_o` is 0 and `qn_o` is 1. The line keeps shifting, so after re-enable the outputs follow R1 with no gap.
- R5: A select increase from `o` to `n` seen at an edge raises `settling_o` after that edge. The flag stays high for exactly (n−o)*STEP_CYC cycles.
- R6: A select decrease raises no flag.
- R7: A 0→1 step of `oe_n_i` while `din_i` or any line stage is 1 raises `settling_o`. The flag stays high until `oe_n_i`=1 and `din_i`=0 have held together on a*STEP_CYC consecutive edges after the disabling edge. Any edge breaking the condition restarts the count.
- R8: A 0→1 step of `oe_n_i` with `din_i` at 0 and the whole line at 0 leaves `settling_o` low.
- R9: While `rst_i` is 1, the line is cleared, `settling_o` goes low, `q_o` is 0 and `qn_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Signal to be delayed |
| addr_i | input | 7 | Delay select, unsigned |
| oe_n_i | input | 1 | Output enable, active low |
| q_o | output | 1 | Delayed signal, true sense |
| qn_o | output | 1 | Delayed signal, inverted |
| settling_o | output | 1 | High while spurious output may appear |

## Verification
A fault in the shift chain or the tap arithmetic shows up as a wrong `q_o` bit. It appears one full delay after the bad stage is loaded, and only for select values that reach that stage. For that reason every one of the 128 select values is run with a pseudo-random stream. A wrong state or counter in the settling machine shows up at once as a flag edge that is one or more cycles early or late. It is compared cycle by cycle against window lengths worked out from the select values and from the run of disabled-low cycles.

// File: rtl/tdl_pkg.sv
`timescale 1ns/1ps
package tdl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ADDR_SETTLE = 2'd1,
        ST_DIS_SETTLE  = 2'd2
    } settle_state_t;
endpackage

// File: rtl/tdl_line.sv
`timescale 1ns/1ps
module tdl_line #(
    parameter int BASE_CYC = 2,
    parameter int STEP_CYC = 1,
    parameter int ADDR_W   = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              din_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              tap_o,
    output logic              busy_o
);
    localparam int NSEL  = 2 ** ADDR_W;
    localparam int LEN   = BASE_CYC + (NSEL - 1) * STEP_CYC;
    localparam int IDX_W = $clog2(LEN);

    logic [LEN-1:0]   stage_q;
    logic [IDX_W-1:0] tap_idx;

    // stage 0 holds the newest sample; everything clears on reset (R9)
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[LEN-2:0], din_i};
        end
    end

    // live select, no capture (R2); index grows with the select (R1)
    assign tap_idx = IDX_W'(BASE_CYC - 1 + int'(addr_i) * STEP_CYC);
    assign tap_o   = stage_q[tap_idx];
    assign busy_o  = |stage_q;
endmodule

// File: rtl/tdl_settle.sv
`timescale 1ns/1ps
module tdl_settle
    import tdl_pkg::*;
#(
    parameter int STEP_CYC = 1,
    parameter int ADDR_W   = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              din_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              oe_n_i,
    input  logic              line_busy_i,
    output logic              settling_o
);
    localparam int MAXW  = (2 ** ADDR_W - 1) * STEP_CYC;
    localparam int CNT_W = $clog2(MAXW + 1);

    settle_state_t     state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, run_nxt, delta, need;
    logic [ADDR_W-1:0] addr_q;
    logic              oe_n_q;
    logic              inc, dis_trig, clear_ok;

    assign inc      = addr_i > addr_q;
    assign delta    = CNT_W'((int'(addr_i) - int'(addr_q)) * STEP_CYC);
    assign need     = CNT_W'(int'(addr_i) * STEP_CYC);
    assign dis_trig = oe_n_i & ~oe_n_q & (din_i | line_busy_i);
    assign clear_ok = oe_n_i & ~din_i;
    assign run_nxt  = !clear_ok ? '0 :
                      (cnt_q == CNT_W'(MAXW)) ? cnt_q : cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (dis_trig && need != '0) begin
            state_d = ST_DIS_SETTLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (inc) begin
                        state_d = ST_ADDR_SETTLE;
                        cnt_d   = delta;
                    end
                end
                ST_ADDR_SETTLE: begin
                    if (inc) begin
                        cnt_d = delta;
                    end else if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_DIS_SETTLE: begin
                    cnt_d = run_nxt;
                    if (run_nxt >= need && !inc) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= addr_i;
            oe_n_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_i;
            oe_n_q  <= oe_n_i;
        end
    end

    always_comb begin
        settling_o = (state_q != ST_IDLE);
    end

    // R5
    inc_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        inc |=> settling_o);
    // R5
    addr_cnt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_ADDR_SETTLE) |-> (cnt_q != '0));
    // R7
    dis_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DIS_SETTLE && !oe_n_i && addr_i != '0) |=> settling_o);
    // R8
    idle_dis_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && oe_n_i && !oe_n_q && !din_i && !line_busy_i && !inc)
        |=> !settling_o);
endmodule

// File: rtl/tapdelay_prog.sv
`timescale 1ns/1ps
module tapdelay_prog #(
    parameter int BASE_CYC = 2,
    parameter int STEP_CYC = 1,
    parameter int ADDR_W   = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              din_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              oe_n_i,
    output logic              q_o,
    output logic              qn_o,
    output logic              settling_o
);
    logic tap, busy;

    tdl_line #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC), .ADDR_W(ADDR_W)) u_line (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .din_i (din_i),
        .addr_i(addr_i),
        .tap_o (tap),
        .busy_o(busy)
    );

    tdl_settle #(.STEP_CYC(STEP_CYC), .ADDR_W(ADDR_W)) u_settle (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .din_i      (din_i),
        .addr_i     (addr_i),
        .oe_n_i     (oe_n_i),
        .line_busy_i(busy),
        .settling_o (settling_o)
    );

    assign q_o  = tap & ~oe_n_i & ~rst_i;
    assign qn_o = ~q_o;

    // R3
    compl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        q_o != qn_o);
    // R4
    clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        oe_n_i |-> (!q_o && qn_o));
    // R9
    rst_out_chk: assert property (@(posedge clk_i)
        rst_i |=> !settling_o);
endmodule

// File: tb/tapdelay_prog_tb.sv
`timescale 1ns/1ps
module tapdelay_prog_tb;
    localparam int BASE = 3;
    localparam int STEP = 2;
    localparam int AW   = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, din, oe_n;
    logic [AW-1:0] addr;
    logic          q, qn, flag;

    tapdelay_prog #(.BASE_CYC(BASE), .STEP_CYC(STEP), .ADDR_W(AW)) u_dut (
        .clk_i(clk), .rst_i(rst), .din_i(din), .addr_i(addr),
        .oe_n_i(oe_n), .q_o(q), .qn_o(qn), .settling_o(flag)
    );

    logic        hist [0:65535];
    int          e = 0;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int unsigned seed = 32'd7;

    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            hist[e] = din;
            e++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[16];
    endfunction

    function automatic logic exp_q();
        int d   = BASE + int'(addr) * STEP;
        int idx = e - d;
        if (oe_n) return 1'b0;
        return (idx >= 0) ? hist[idx] : 1'b0;
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (edge %0d, sel %0d)",
                     tag, what, act, expv, e, addr);
        end
    endtask

    task automatic check_outs(string tag);
        logic x;
        x = exp_q();
        check_bit(tag, "q_o", q, x);
        check_bit("R3", "qn_o", qn, ~x);
    endtask

    initial begin
        int run;
        rst  = 1'b1;
        din  = 1'b0;
        oe_n = 1'b0;
        addr = '0;
        repeat (3) @(negedge clk);
        din = 1'b1;
        repeat (4) @(negedge clk);
        // R9: reset holds disabled levels and no flag
        check_bit("R9", "q_o", q, 1'b0);
        check_bit("R9", "qn_o", qn, 1'b1);
        check_bit("R9", "settling_o", flag, 1'b0);
        din = 1'b0;
        rst = 1'b0;

        // R1 / R2: every select value with a random stream
        for (int a = 0; a < 128; a++) begin
            addr = a[AW-1:0];
            for (int k = 0; k < BASE + a * STEP + 8; k++) begin
                din = rnd();
                @(negedge clk);
                check_outs(k == 0 ? "R2" : "R1");
            end
        end

        // R6: decrease gives no flag
        addr = 7'd10;
        for (int k = 0; k < 40; k++) begin
            din = rnd();
            @(negedge clk);
            check_bit("R6", "settling_o", flag, 1'b0);
            check_outs("R1");
        end

        // R5: increase 10 -> 15 gives 5*STEP flag cycles
        addr = 7'd15;
        for (int k = 0; k < 14; k++) begin
            din = rnd();
            @(negedge clk);
            check_bit("R5", "settling_o", flag, k < 5 * STEP);
            check_outs("R2");
        end

        // R6: decrease 15 -> 4
        addr = 7'd4;
        for (int k = 0; k < 20; k++) begin
            din = rnd();
            @(negedge clk);
            check_bit("R6", "settling_o", flag, 1'b0);
        end

        // R7: disable with a busy line, select 6 needs 12 clear edges
        addr = 7'd6;
        for (int k = 0; k < 6; k++) begin
            din = 1'b1;
            @(negedge clk);
        end
        oe_n = 1'b1;
        run  = 0;
        for (int k = 0; k < 30; k++) begin
            din = (k < 3 || k == 8) ? 1'b1 : 1'b0;
            @(negedge clk);
            if (k > 0) run = din ? 0 : run + 1;
            check_bit("R7", "settling_o", flag, run < 6 * STEP);
            check_outs("R4");
        end
        // R4: line kept moving while clamped
        oe_n = 1'b0;
        for (int k = 0; k < BASE + 6 * STEP + 10; k++) begin
            din = rnd();
            @(negedge clk);
            check_outs("R4");
        end

        // R8: disable with an empty line
        din = 1'b0;
        repeat (BASE + 127 * STEP + 5) @(negedge clk);
        oe_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check_bit("R8", "settling_o", flag, 1'b0);
            check_outs("R4");
        end
        oe_n = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule